// File: doc/BRIEF.md
# Chunking Copy-Descriptor Sequencer

This block stands between a queue of memory-copy requests and a single copy channel. Each request (a descriptor) carries a source address, a destination address and a byte count that may be as wide as 64 bits. Descriptors are pushed through a valid/ready interface into a small FIFO. The sequencer takes one at a time and drives the channel through a register-write port.

The channel can only move a bounded run per start, so a long descriptor is cut into consecutive chunks. Every chunk follows the same pattern. The sequencer first issues a warm reset to the channel. It then waits for the channel's busy flag to fall, checking it at a fixed poll interval. Next it writes the addresses and the chunk length, and finally it sets the start bit. When the channel reports that the chunk is finished, the sequencer moves both addresses forward and reduces the remaining count. Once the count reaches zero, it raises a completion pulse for that descriptor and takes the next one from the FIFO.

If the channel stays busy for too long, a sticky error is raised and the chunk is programmed anyway.

Top module: `chunk_seq`

## Requirements
- R1: A descriptor is accepted on a clock edge where `push_valid_i` and `push_ready_o` are both high. The FIFO holds `DEPTH` entries. `fifo_full_o` is high when all `DEPTH` entries are occupied, `push_ready_o` is the inverse of `fifo_full_o`, and `fifo_empty_o` is high when no entry is stored.
- R2: At most one descriptor is active at a time. A descriptor leaves the FIFO only when none is active, and descriptors are served in push order.
- R3: The length of each chunk is the smaller of the remaining count and `MAX_CHUNK` (default 0x0FFFFFFF).
- R4: Each chunk begins with a single write with select code 0 (warm reset, data 1). The sequencer then samples `busy_i` once every `POLL_CYC` cycles. Programming starts only after a sample has found `busy_i` low.
- R5: Programming consists of writes on consecutive cycles with these select codes: 1 = source low word, 2 = source high word, 3 = destination low word, 4 = destination high word, 5 = chunk length, 6 = start (data 1).
- R6: When `chunk_done_i` is seen, the source and destination each advance by the chunk length and the remaining count drops by the same amount. If the count is still nonzero, the next chunk begins.
- R7: `desc_done_o` pulses for one cycle exactly once per descriptor, in the cycle in which its remaining count reaches zero.
- R8: If `busy_i` has not been seen low within `TIMEOUT_CYC` cycles of waiting, `timeout_err_o` is set and programming proceeds. The flag remains set until reset.
- R9: A descriptor whose length is zero is retired with a `desc_done_o` pulse and causes no channel write.
- R10: While reset is applied and right after it, `push_ready_o` = 1, `fifo_empty_o` = 1, `fifo_full_o` = 0, `reg_we_o` = 0, `desc_done_o` = 0 and `timeout_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Descriptor offered |
| push_ready_o | output | 1 | FIFO can accept a descriptor |
| push_src_i | input | ADDR_W | Source address |
| push_dst_i | input | ADDR_W | Destination address |
| push_len_i | input | LEN_W | Byte count |
| fifo_full_o | output | 1 | FIFO full |
| fifo_empty_o | output | 1 | FIFO empty |
| busy_i | input | 1 | Channel busy flag |
| chunk_done_i | input | 1 | Channel finished the current chunk (one-cycle pulse) |
| reg_we_o | output | 1 | Channel register write strobe |
| reg_sel_o | output | 3 | Register select code (see R4, R5) |
| reg_wdata_o | output | REG_W | Register write data |
| desc_done_o | output | 1 | Descriptor retired (pulse) |
| timeout_err_o | output | 1 | Sticky wait-for-idle timeout |

## Verification
The hardest case to reach from the ports is the timeout path. It needs the channel to stay busy past the whole timeout window, and programming must still follow in order afterwards. The bench's channel responder has a switch that holds busy high. With the switch on, the bench checks three things: the exact gap between the warm-reset write and the first address write, that the error flag has risen, and that the flag stays set through a later descriptor that completes normally. The chunk-boundary cases are driven from the descriptor table. These include a count exactly equal to the cap, one byte over the cap, a count that needs four chunks, and a source address whose low word carries into the high word between chunks.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam logic [2:0] SEL_WRST   = 3'd0;
  localparam logic [2:0] SEL_SRC_LO = 3'd1;
  localparam logic [2:0] SEL_SRC_HI = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_DST_HI = 3'd4;
  localparam logic [2:0] SEL_LEN    = 3'd5;
  localparam logic [2:0] SEL_GO     = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRST, ST_WAIT, ST_PROG, ST_RUN
  } seq_state_e;
endpackage

// File: rtl/seq_desc_fifo.sv
module seq_desc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_next(wr_q);
      if (pop_i)  rd_q <= ptr_next(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seq_idle_wait.sv
module seq_idle_wait #(
  parameter int POLL_CYC    = 500,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic busy_i,
  output logic idle_o,
  output logic tout_o
);
  localparam int PCW = $clog2(POLL_CYC + 1);
  localparam int TCW = $clog2(TIMEOUT_CYC + 1);

  logic [PCW-1:0] poll_q;
  logic [TCW-1:0] tot_q;
  logic           sample;

  assign sample = en_i && (poll_q == PCW'(POLL_CYC - 1));
  assign idle_o = sample && !busy_i;
  assign tout_o = en_i && !idle_o && (tot_q == TCW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q <= '0;
      tot_q  <= '0;
    end else if (!en_i) begin
      poll_q <= '0;
      tot_q  <= '0;
    end else begin
      poll_q <= sample ? '0 : poll_q + 1'b1;
      tot_q  <= tot_q + 1'b1;
    end
  end
endmodule

// File: rtl/chunk_seq.sv
module chunk_seq
  import seq_pkg::*;
#(
  parameter int              ADDR_W      = 64,
  parameter int              LEN_W       = 64,
  parameter int              REG_W       = 32,
  parameter int              DEPTH       = 4,
  parameter int              POLL_CYC    = 500,
  parameter int              TIMEOUT_CYC = 50000,
  parameter logic [LEN_W-1:0] MAX_CHUNK  = 'h0FFF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_valid_i,
  output logic              push_ready_o,
  input  logic [ADDR_W-1:0] push_src_i,
  input  logic [ADDR_W-1:0] push_dst_i,
  input  logic [LEN_W-1:0]  push_len_i,
  output logic              fifo_full_o,
  output logic              fifo_empty_o,
  input  logic              busy_i,
  input  logic              chunk_done_i,
  output logic              reg_we_o,
  output logic [2:0]        reg_sel_o,
  output logic [REG_W-1:0]  reg_wdata_o,
  output logic              desc_done_o,
  output logic              timeout_err_o
);
  localparam int DW = 2 * ADDR_W + LEN_W;

  seq_state_e        state_q;
  logic [2:0]        step_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  rem_q, chunk;
  logic              err_q;
  logic [DW-1:0]     head;
  logic [ADDR_W-1:0] head_src, head_dst;
  logic [LEN_W-1:0]  head_len;
  logic              fifo_push, fifo_pop, seq_busy;
  logic              idle_ok, wait_tout, last_chunk;

  assign fifo_push    = push_valid_i && !fifo_full_o;
  assign fifo_pop     = (state_q == ST_IDLE) && !fifo_empty_o;
  assign push_ready_o = !fifo_full_o;
  assign seq_busy     = (state_q != ST_IDLE);

  seq_desc_fifo #(.W(DW), .DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .wdata_i ({push_src_i, push_dst_i, push_len_i}),
    .pop_i   (fifo_pop),
    .rdata_o (head),
    .full_o  (fifo_full_o),
    .empty_o (fifo_empty_o)
  );

  assign {head_src, head_dst, head_len} = head;

  seq_idle_wait #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) i_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_WAIT),
    .busy_i (busy_i),
    .idle_o (idle_ok),
    .tout_o (wait_tout)
  );

  assign chunk      = (rem_q < MAX_CHUNK) ? rem_q : MAX_CHUNK;
  assign last_chunk = (rem_q == chunk);

  assign desc_done_o   = (fifo_pop && (head_len == '0)) ||
                         ((state_q == ST_RUN) && chunk_done_i && last_chunk);
  assign timeout_err_o = err_q;
  assign reg_we_o      = (state_q == ST_WRST) || (state_q == ST_PROG);
  assign reg_sel_o     = (state_q == ST_WRST) ? SEL_WRST : step_q;

  always_comb begin
    reg_wdata_o = '0;
    case (reg_sel_o)
      SEL_WRST:   reg_wdata_o = REG_W'(1);
      SEL_SRC_LO: reg_wdata_o = REG_W'(src_q);
      SEL_SRC_HI: reg_wdata_o = REG_W'(src_q >> REG_W);
      SEL_DST_LO: reg_wdata_o = REG_W'(dst_q);
      SEL_DST_HI: reg_wdata_o = REG_W'(dst_q >> REG_W);
      SEL_LEN:    reg_wdata_o = REG_W'(chunk);
      SEL_GO:     reg_wdata_o = REG_W'(1);
      default:    reg_wdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= SEL_SRC_LO;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (fifo_pop) begin
          src_q <= head_src;
          dst_q <= head_dst;
          rem_q <= head_len;
          if (head_len != '0) state_q <= ST_WRST;
        end
        ST_WRST: state_q <= ST_WAIT;
        ST_WAIT: if (idle_ok || wait_tout) begin
          state_q <= ST_PROG;
          step_q  <= SEL_SRC_LO;
          if (wait_tout) err_q <= 1'b1;
        end
        ST_PROG: begin
          if (step_q == SEL_GO) state_q <= ST_RUN;
          else                  step_q  <= step_q + 1'b1;
        end
        ST_RUN: if (chunk_done_i) begin
          src_q   <= src_q + ADDR_W'(chunk);
          dst_q   <= dst_q + ADDR_W'(chunk);
          rem_q   <= rem_q - chunk;
          state_q <= last_chunk ? ST_IDLE : ST_WRST;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter logic [63:0] LEN_CAP = 64'h0FFF_FFFF,
  parameter int          REG_W   = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_ready_o,
  input logic             fifo_full_o,
  input logic             fifo_empty_o,
  input logic             busy_i,
  input logic             reg_we_o,
  input logic [2:0]       reg_sel_o,
  input logic [REG_W-1:0] reg_wdata_o,
  input logic             desc_done_o,
  input logic             timeout_err_o,
  input logic             fifo_pop,
  input logic             seq_busy
);
  // R1
  full_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> !push_ready_o);
  // R1
  flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_full_o && fifo_empty_o));
  // R2
  one_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop |-> !seq_busy);
  // R3
  len_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_sel_o == 3'd5) |-> (64'(reg_wdata_o) <= LEN_CAP && reg_wdata_o != '0));
  // R4
  idle_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_sel_o == 3'd1) |-> (!$past(busy_i) || timeout_err_o));
  // R5
  prog_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_sel_o >= 3'd2) |-> ($past(reg_we_o) && $past(reg_sel_o) == reg_sel_o - 3'd1));
  // R7
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_done_o |-> !reg_we_o);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(timeout_err_o) |-> timeout_err_o);
endmodule

bind chunk_seq seq_chk #(.LEN_CAP(64'(MAX_CHUNK)), .REG_W(REG_W)) i_seq_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .push_ready_o  (push_ready_o),
  .fifo_full_o   (fifo_full_o),
  .fifo_empty_o  (fifo_empty_o),
  .busy_i        (busy_i),
  .reg_we_o      (reg_we_o),
  .reg_sel_o     (reg_sel_o),
  .reg_wdata_o   (reg_wdata_o),
  .desc_done_o   (desc_done_o),
  .timeout_err_o (timeout_err_o),
  .fifo_pop      (fifo_pop),
  .seq_busy      (seq_busy)
);

// File: tb/test_chunk_seq.sv
module test_chunk_seq;
  localparam int P = 4, T = 40, D = 4, BUSY = 6, RUN = 10;
  localparam logic [63:0] CAP = 64'h0FFF_FFFF;
  localparam int NT = 7;
  // src, dst, len, expected chunks
  localparam logic [63:0] TBL [NT][4] = '{
    '{64'h0000_0000_0000_1000, 64'h0000_8000_0000_2000, 64'h40,          64'd1},
    '{64'h0000_0000_FFFF_FFF0, 64'h0000_0001_0000_0000, 64'h1000_0005,   64'd2},
    '{64'h0000_0012_0000_0000, 64'h0000_0034_0000_0000, 64'h0FFF_FFFF,   64'd1},
    '{64'h0000_0000_0000_0100, 64'h0000_0000_0000_0200, 64'h1000_0000,   64'd2},
    '{64'h0000_0000_0000_0300, 64'h0000_0000_0000_0400, 64'h0,           64'd0},
    '{64'h0000_0000_0000_0500, 64'h0000_0000_0000_0600, 64'h3000_0000,   64'd4},
    '{64'h0000_0000_0000_0007, 64'h0000_0000_0000_0009, 64'h1,           64'd1}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        push_valid = 1'b0, push_ready;
  logic [63:0] push_src = '0, push_dst = '0, push_len = '0;
  logic        full, empty, busy, chunk_done;
  logic        reg_we, desc_done, terr;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        hold_busy = 1'b0;
  int          busy_cnt, run_cnt;
  int          checks = 0, errors = 0, ndone = 0, cyc = 0, wrst_cyc = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  chunk_seq #(.DEPTH(D), .POLL_CYC(P), .TIMEOUT_CYC(T)) i_chunk_seq (
    .clk_i(clk), .rst_ni(rst_n), .push_valid_i(push_valid), .push_ready_o(push_ready),
    .push_src_i(push_src), .push_dst_i(push_dst), .push_len_i(push_len),
    .fifo_full_o(full), .fifo_empty_o(empty), .busy_i(busy), .chunk_done_i(chunk_done),
    .reg_we_o(reg_we), .reg_sel_o(reg_sel), .reg_wdata_o(reg_wdata),
    .desc_done_o(desc_done), .timeout_err_o(terr)
  );

  // behavioural channel
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= 0;
      run_cnt  <= 0;
    end else begin
      cyc <= cyc + 1;
      if (reg_we && reg_sel == 3'd0) busy_cnt <= BUSY;
      else if (busy_cnt != 0)        busy_cnt <= busy_cnt - 1;
      if (reg_we && reg_sel == 3'd6) run_cnt <= RUN;
      else if (run_cnt != 0)         run_cnt <= run_cnt - 1;
    end
  end
  assign busy       = hold_busy || (busy_cnt != 0);
  assign chunk_done = (run_cnt == 1);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  typedef struct {
    logic [63:0] src, dst, len;
    int          nch;
  } exp_t;
  exp_t        q[$];
  bit          m_act = 1'b0;
  logic [63:0] m_src, m_dst, m_rem, m_ch;
  int          m_nch, m_chunks;
  logic [2:0]  m_step = 3'd0;

  // scoreboard on channel writes and completions
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        m_ch = (m_rem < CAP) ? m_rem : CAP;
        if (reg_sel == 3'd0) begin
          if (!m_act) begin
            chk(q.size() != 0, "R2 unexpected descriptor", 64'(q.size()), 1);
            if (q.size() != 0) begin
              chk(q[0].len != 0, "R9 zero-length started", q[0].len, 0);
              m_src = q[0].src; m_dst = q[0].dst; m_rem = q[0].len;
              m_nch = q[0].nch; m_chunks = 0; m_act = 1'b1;
              void'(q.pop_front());
            end
          end
          chk(m_step == 3'd0, "R4 warm reset out of order", 64'(m_step), 0);
          chk(reg_wdata == 32'd1, "R4 warm reset data", 64'(reg_wdata), 1);
          m_step = 3'd1;
          wrst_cyc = cyc;
        end else begin
          m_ch = (m_rem < CAP) ? m_rem : CAP;
          chk(reg_sel == m_step, "R5 select order", 64'(reg_sel), 64'(m_step));
          case (reg_sel)
            3'd1: begin
              chk(reg_wdata == m_src[31:0], "R6 src lo", 64'(reg_wdata), 64'(m_src[31:0]));
              if (hold_busy)
                chk(cyc - wrst_cyc == T + 1, "R8 timeout gap", 64'(cyc - wrst_cyc), 64'(T + 1));
              else
                chk(!busy, "R4 programmed while busy", 64'(busy), 0);
            end
            3'd2: chk(reg_wdata == m_src[63:32], "R6 src hi", 64'(reg_wdata), 64'(m_src[63:32]));
            3'd3: chk(reg_wdata == m_dst[31:0], "R6 dst lo", 64'(reg_wdata), 64'(m_dst[31:0]));
            3'd4: chk(reg_wdata == m_dst[63:32], "R6 dst hi", 64'(reg_wdata), 64'(m_dst[63:32]));
            3'd5: chk(reg_wdata == m_ch[31:0], "R3 chunk length", 64'(reg_wdata), m_ch);
            3'd6: begin
              chk(reg_wdata == 32'd1, "R5 start data", 64'(reg_wdata), 1);
              m_src = m_src + m_ch; m_dst = m_dst + m_ch; m_rem = m_rem - m_ch;
              m_chunks++;
            end
            default: chk(1'b0, "R5 bad select", 64'(reg_sel), 0);
          endcase
          m_step = (reg_sel == 3'd6) ? 3'd0 : m_step + 3'd1;
        end
      end
      if (desc_done) begin
        ndone++;
        if (m_act) begin
          chk(m_rem == 0, "R7 early completion", m_rem, 0);
          chk(m_chunks == m_nch, "R6 chunk count", 64'(m_chunks), 64'(m_nch));
          m_act = 1'b0;
        end else if (q.size() != 0 && q[0].len == 0) begin
          chk(1'b1, "R9 zero-length retire", 0, 0);
          void'(q.pop_front());
        end else begin
          chk(1'b0, "R7 spurious completion", 1, 0);
        end
      end
    end
  end

  task automatic push(input logic [63:0] s, input logic [63:0] d, input logic [63:0] l, input int n);
    exp_t e;
    e.src = s; e.dst = d; e.len = l; e.nch = n;
    @(negedge clk);
    q.push_back(e);
    push_valid = 1'b1; push_src = s; push_dst = d; push_len = l;
    while (!push_ready) @(negedge clk);
    @(posedge clk);
    #1 push_valid = 1'b0;
  endtask

  task automatic wait_done(input int n);
    int guard = 0;
    while (ndone < n && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    chk(ndone == n, "R7 completion count", 64'(ndone), 64'(n));
  endtask

  task automatic check_reset_state();
    chk(push_ready == 1'b1, "R10 push_ready", 64'(push_ready), 1);
    chk(empty == 1'b1,      "R10 empty", 64'(empty), 1);
    chk(full == 1'b0,       "R10 full", 64'(full), 0);
    chk(reg_we == 1'b0,     "R10 reg_we", 64'(reg_we), 0);
    chk(desc_done == 1'b0,  "R10 desc_done", 64'(desc_done), 0);
    chk(terr == 1'b0,       "R10 timeout_err", 64'(terr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    // table of descriptors
    for (int i = 0; i < NT; i++)
      push(TBL[i][0], TBL[i][1], TBL[i][2], int'(TBL[i][3]));
    wait_done(NT);
    chk(q.size() == 0, "R2 all served in order", 64'(q.size()), 0);
    chk(empty, "R1 empty after drain", 64'(empty), 1);

    // fill the FIFO behind a long descriptor
    push(64'h1_0000, 64'h2_0000, 64'h3000_0000, 4);
    while (!empty) @(negedge clk);
    for (int i = 0; i < D; i++) push(64'h100 * i, 64'h9000 + i, 64'h20 + i, 1);
    @(negedge clk);
    chk(full == 1'b1, "R1 full flag", 64'(full), 1);
    chk(push_ready == 1'b0, "R1 ready low when full", 64'(push_ready), 0);
    wait_done(NT + 1 + D);

    // wait-for-idle timeout
    chk(terr == 1'b0, "R8 no error before timeout", 64'(terr), 0);
    hold_busy = 1'b1;
    push(64'hA000, 64'hB000, 64'h8, 1);
    wait_done(NT + 2 + D);
    chk(terr == 1'b1, "R8 timeout flag", 64'(terr), 1);
    hold_busy = 1'b0;
    push(64'hC000, 64'hD000, 64'h8, 1);
    wait_done(NT + 3 + D);
    chk(terr == 1'b1, "R8 flag sticky", 64'(terr), 1);

    // reset clears the sticky flag
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule